// File: doc/BRIEF.md
# Two-Stage Polyphase Comb Decimator

This block takes the single-bit output of an oversampling modulator and lowers its sample rate by 32. It maps each bit to a signed ±1 value. It then filters and decimates the stream in two cascaded fourth-order comb (sinc⁴) sections. The first section decimates by 8 and the second by 4. With a 5.12 MHz bit rate, the first section produces words at 640 kHz and the second at 160 kHz. A downstream half-band chain then completes the remaining rate reduction.

Neither section is recursive. Each one is a decimating FIR whose taps are the coefficients of (1 + z⁻¹ + … + z⁻⁽ᴹ⁻¹⁾)⁴. It is arranged in transposed polyphase form: a small bank of partial-sum accumulators collects, for every incoming sample, the contributions owed to each pending output. The accumulator holding the oldest output is emitted once per M inputs, and the bank then shifts.

The block runs on a fast system clock. A `bit_valid` strobe marks the clock cycles that carry a modulator bit. The first outputs after reset, whose filter windows still reach back before reset, are held back by a fixed count.

Top module: `cmb_decim32`

## Requirements
- R1: An accepted bit of 1 enters the filters as +1 and a bit of 0 as −1, so a constant stream of ones gives +1048576 and a constant stream of zeros gives −1048576 on every valid output.
- R2: Exactly one output is produced for every 32 accepted bits, counting from the first bit after reset. `out_valid` is high for a single clock cycle per output.
- R3: Number the accepted bits x[0], x[1], … from reset. Stage one gives y1[n] = Σ h8[k]·x[8n+7−k] for k = 0..28, and stage two gives y2[m] = Σ h4[k]·y1[4m+3−k] for k = 0..12. Here hM[k] is the number of ways to write k as an ordered sum of four integers in 0..M−1, and terms with negative indices are zero. Valid output number j (counted from 0) carries y2[j+3].
- R4: `out_valid` is high in the second clock cycle after the cycle in which the last bit of the output's 32-bit frame (bit 32m+31) is presented with `bit_valid` high.
- R5: The first three outputs after reset are suppressed. The first `out_valid` follows the 128th accepted bit.
- R6: Asserting `rst_n` clears the phase counters and all partial-sum accumulators, even in the middle of a frame. Bits accepted afterwards are filtered as if no earlier bits existed.
- R7: In cycles with `bit_valid` low, `bit_in` is ignored and no filter state advances.
- R8: `out_data` is a 22-bit two's-complement word that holds the full gain of 8⁴·4⁴ = 1048576 without overflow for any input pattern.
- R9: While reset is asserted, `out_valid` is 0 and `out_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, asynchronous assertion |
| bit_valid | input | 1 | High in cycles that carry a modulator bit |
| bit_in | input | 1 | Modulator output bit |
| out_valid | output | 1 | One-cycle strobe marking a decimated sample |
| out_data | output | OUT_W (22) | Signed decimated sample |

## Verification
The bench builds the block with its default parameters: decimation factors 8 and 4, fourth order, and a full-precision 22-bit output. With these values, constant streams reach the exact ±2²⁰ full-scale extremes, and the settle count of three frames can be observed directly. Bursts with no idle cycles are mixed with random idle gaps during which `bit_in` toggles. Resets placed in mid-frame show whether stale phase or partial sums leak into the first settled output.

// File: rtl/cmb_dec_pkg.sv
package cmb_dec_pkg;

  localparam int CMB_MAX_TAPS = 64;

  // Tap k of the polynomial (1 + z^-1 + ... + z^-(m-1))^order, by repeated convolution.
  function automatic int cmb_tap(input int m, input int order, input int k);
    int cur [CMB_MAX_TAPS];
    int nxt [CMB_MAX_TAPS];
    int len;
    for (int i = 0; i < CMB_MAX_TAPS; i++) cur[i] = 0;
    cur[0] = 1;
    len = 1;
    for (int s = 0; s < order; s++) begin
      for (int i = 0; i < CMB_MAX_TAPS; i++) nxt[i] = 0;
      for (int i = 0; i < len; i++) begin
        for (int d = 0; d < m; d++) begin
          if (i + d < CMB_MAX_TAPS) nxt[i + d] = nxt[i + d] + cur[i];
        end
      end
      len = len + m - 1;
      for (int i = 0; i < CMB_MAX_TAPS; i++) cur[i] = nxt[i];
    end
    if (k < 0 || k >= len || k >= CMB_MAX_TAPS) return 0;
    return cur[k];
  endfunction

  function automatic int cmb_pow(input int b, input int e);
    int r;
    r = 1;
    for (int i = 0; i < e; i++) r = r * b;
    return r;
  endfunction

endpackage

// File: rtl/cmb_poly_stage.sv
module cmb_poly_stage #(
  parameter int M      = 8,
  parameter int ORDER  = 4,
  parameter int IN_W   = 2,
  parameter int OUT_W  = 14,
  parameter int IN_MAX = 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic signed [IN_W-1:0]  in_data,
  output logic                    out_valid,
  output logic signed [OUT_W-1:0] out_data
);
  import cmb_dec_pkg::*;

  localparam int TAPS = ORDER * (M - 1) + 1;
  localparam int NACC = (TAPS - 1) / M + 1;
  localparam int PW   = (M > 1) ? $clog2(M) : 1;
  localparam int GAIN = cmb_pow(M, ORDER);
  localparam logic [PW-1:0] LAST_PH = PW'(M - 1);

  // Coefficient owed by accumulator j for an input arriving in phase q.
  logic signed [OUT_W-1:0] coef_tab [NACC][M];
  for (genvar j = 0; j < NACC; j++) begin : g_acc
    for (genvar q = 0; q < M; q++) begin : g_ph
      localparam int K = M * j + (M - 1 - q);
      assign coef_tab[j][q] = OUT_W'(cmb_tap(M, ORDER, K));
    end
  end

  logic [PW-1:0]           phase_q, phase_d;
  logic signed [OUT_W-1:0] acc_q [NACC];
  logic signed [OUT_W-1:0] acc_d [NACC];
  logic                    vld_q, vld_d;
  logic signed [OUT_W-1:0] dat_q, dat_d;
  logic signed [OUT_W-1:0] in_ext;
  logic signed [OUT_W-1:0] term [NACC];

  assign in_ext = OUT_W'(in_data);

  always_comb begin
    for (int j = 0; j < NACC; j++) term[j] = in_ext * coef_tab[j][phase_q];
  end

  always_comb begin
    phase_d = phase_q;
    vld_d   = 1'b0;
    dat_d   = dat_q;
    for (int j = 0; j < NACC; j++) acc_d[j] = acc_q[j];
    if (in_valid) begin
      if (phase_q == LAST_PH) begin
        phase_d = '0;
        vld_d   = 1'b1;
        dat_d   = acc_q[0] + term[0];
        for (int j = 0; j < NACC - 1; j++) acc_d[j] = acc_q[j + 1] + term[j + 1];
        acc_d[NACC - 1] = '0;
      end else begin
        phase_d = phase_q + 1'b1;
        for (int j = 0; j < NACC; j++) acc_d[j] = acc_q[j] + term[j];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      vld_q   <= 1'b0;
      dat_q   <= '0;
      for (int j = 0; j < NACC; j++) acc_q[j] <= '0;
    end else begin
      vld_q <= vld_d;
      if (in_valid) begin
        phase_q <= phase_d;
        dat_q   <= dat_d;
        for (int j = 0; j < NACC; j++) acc_q[j] <= acc_d[j];
      end
    end
  end

  assign out_valid = vld_q;
  assign out_data  = dat_q;

  // R7: idle cycles leave the phase untouched
  p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(phase_q));

  // R2: an emitted word always coincides with a phase restart
  p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (phase_q == '0));

  // R8: stage result stays within its own full-scale gain
  p_stage_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_data <= GAIN * IN_MAX && out_data >= -(GAIN * IN_MAX)));

endmodule

// File: rtl/cmb_settle_gate.sv
module cmb_settle_gate #(
  parameter int SETTLE = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  output logic out_valid
);
  localparam int CNW = $clog2(SETTLE + 1);

  logic [CNW-1:0] cnt_q, cnt_d;
  logic           done;
  logic           cnt_en;

  assign done   = (cnt_q == CNW'(SETTLE));
  assign cnt_en = in_valid && !done;

  always_comb begin
    cnt_d = cnt_q;
    if (cnt_en) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign out_valid = in_valid && done;

  // R5: once settled, the gate stays open until reset
  p_settle_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);

endmodule

// File: rtl/cmb_out_scale.sv
module cmb_out_scale #(
  parameter int IN_W  = 22,
  parameter int OUT_W = 22
) (
  input  logic signed [IN_W-1:0]  din,
  output logic signed [OUT_W-1:0] dout
);
  if (OUT_W >= IN_W) begin : g_ext
    assign dout = OUT_W'(din);
  end else begin : g_cut
    assign dout = din[IN_W-1 -: OUT_W];
  end
endmodule

// File: rtl/cmb_decim32.sv
module cmb_decim32 #(
  parameter int OSR1  = 8,
  parameter int OSR2  = 4,
  parameter int ORDER = 4,
  parameter int OUT_W = 2 + ORDER * ($clog2(OSR1) + $clog2(OSR2))
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    bit_valid,
  input  logic                    bit_in,
  output logic                    out_valid,
  output logic signed [OUT_W-1:0] out_data
);
  import cmb_dec_pkg::*;

  localparam int W0      = 2;
  localparam int W1      = W0 + ORDER * $clog2(OSR1);
  localparam int W2      = W1 + ORDER * $clog2(OSR2);
  localparam int TAPS1   = ORDER * (OSR1 - 1) + 1;
  localparam int TAPS2   = ORDER * (OSR2 - 1) + 1;
  localparam int SETTLE1 = (TAPS1 - 1) / OSR1;
  localparam int SETTLE2 = (TAPS2 - 1 + SETTLE1) / OSR2;
  localparam int GAIN1   = cmb_pow(OSR1, ORDER);

  logic signed [W0-1:0] in_word;
  logic                 s1_valid, s2_valid;
  logic signed [W1-1:0] s1_data;
  logic signed [W2-1:0] s2_data;

  assign in_word = bit_in ? 2'sb01 : 2'sb11;

  cmb_poly_stage #(
    .M(OSR1), .ORDER(ORDER), .IN_W(W0), .OUT_W(W1), .IN_MAX(1)
  ) u_stage1 (
    .clk(clk), .rst_n(rst_n), .in_valid(bit_valid), .in_data(in_word),
    .out_valid(s1_valid), .out_data(s1_data)
  );

  cmb_poly_stage #(
    .M(OSR2), .ORDER(ORDER), .IN_W(W1), .OUT_W(W2), .IN_MAX(GAIN1)
  ) u_stage2 (
    .clk(clk), .rst_n(rst_n), .in_valid(s1_valid), .in_data(s1_data),
    .out_valid(s2_valid), .out_data(s2_data)
  );

  cmb_settle_gate #(.SETTLE(SETTLE2)) u_gate (
    .clk(clk), .rst_n(rst_n), .in_valid(s2_valid), .out_valid(out_valid)
  );

  cmb_out_scale #(.IN_W(W2), .OUT_W(OUT_W)) u_scale (
    .din(s2_data), .dout(out_data)
  );

  // R2: output strobe lasts a single cycle
  p_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

endmodule

// File: tb/cmb_decim32_tb_top.sv
`timescale 1ns/1ps
module cmb_decim32_tb_top;
  localparam int M1 = 8, M2 = 4, ORD = 4, OW = 22;
  localparam int FRAME = 32, SETTLE = 3, LAT = 2, FULL = 1048576;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_valid = 1'b0;
  logic bit_in = 1'b0;
  logic out_valid;
  logic signed [OW-1:0] out_data;

  cmb_decim32 #(.OSR1(M1), .OSR2(M2), .ORDER(ORD), .OUT_W(OW)) dut_i (
    .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .bit_in(bit_in),
    .out_valid(out_valid), .out_data(out_data)
  );

  always #2 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0, n_err = 0;
  int h1 [29];
  int h2 [13];
  bit xb [$];
  int xcyc [$];
  int got_cnt = 0;
  int last_out = 0;
  bit prev_v = 1'b0;
  bit finished = 1'b0;
  string cur_req = "R3";

  function automatic int ways(int m, int k);
    int c;
    c = 0;
    for (int a = 0; a < m; a++)
      for (int b = 0; b < m; b++)
        for (int e = 0; e < m; e++) begin
          int d;
          d = k - a - b - e;
          if (d >= 0 && d < m) c++;
        end
    return c;
  endfunction

  function automatic int y1_at(int n);
    int s;
    s = 0;
    if (n < 0) return 0;
    for (int k = 0; k < 29; k++) begin
      int idx;
      idx = 8 * n + 7 - k;
      if (idx >= 0 && idx < xb.size()) s += h1[k] * (xb[idx] ? 1 : -1);
    end
    return s;
  endfunction

  function automatic int y2_at(int m);
    int s;
    s = 0;
    for (int k = 0; k < 13; k++) s += h2[k] * y1_at(4 * m + 3 - k);
    return s;
  endfunction

  task automatic check(string req, int act, int exp, string what);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Output monitor: value (R3), latency (R4), pulse width (R2)
  always @(negedge clk) begin
    if (rst_n) begin
      if (out_valid) begin
        int m;
        int lastbit;
        m = got_cnt + SETTLE;
        lastbit = FRAME * m + FRAME - 1;
        if (lastbit < xb.size()) begin
          check(cur_req, int'(out_data), y2_at(m), "sample value");
          check("R4", cyc, xcyc[lastbit] + LAT, "output cycle");
        end else begin
          check("R2", xb.size(), lastbit + 1, "bits accepted before output");
        end
        if (prev_v) check("R2", 1, 0, "out_valid high on consecutive cycles");
        last_out = int'(out_data);
        got_cnt++;
      end
      prev_v = out_valid;
    end else begin
      prev_v = 1'b0;
    end
  end

  task automatic send_bit(bit b, int gap);
    bit_valid = 1'b1;
    bit_in = b;
    xb.push_back(b);
    xcyc.push_back(cyc);
    @(negedge clk);
    bit_valid = 1'b0;
    for (int g = 0; g < gap; g++) begin
      bit_in = 1'($urandom);
      @(negedge clk);
    end
  endtask

  task automatic apply_reset();
    rst_n = 1'b0;
    bit_valid = 1'b0;
    repeat (3) @(negedge clk);
    check("R9", int'(out_valid), 0, "out_valid during reset");
    check("R9", int'(out_data), 0, "out_data during reset");
    xb.delete();
    xcyc.delete();
    got_cnt = 0;
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic end_segment(string req);
    int exp;
    repeat (LAT + 2) @(negedge clk);
    #1;
    exp = xb.size() / FRAME - SETTLE;
    if (exp < 0) exp = 0;
    check(req, got_cnt, exp, "output count");
    @(negedge clk);
  endtask

  initial begin
    int unsigned seed;
    seed = $urandom(32'h1CE5);
    for (int k = 0; k < 29; k++) h1[k] = ways(M1, k);
    for (int k = 0; k < 13; k++) h2[k] = ways(M2, k);
    @(negedge clk);
    apply_reset();

    // R1 / R8: all ones gives positive full scale; R5 count
    for (int i = 0; i < 6 * FRAME; i++) send_bit(1'b1, 0);
    end_segment("R5");
    check("R1", last_out, FULL, "all-ones output");
    check("R8", last_out, FULL, "positive full scale");

    // R5: exactly 4 frames, first valid after 128th bit
    apply_reset();
    for (int i = 0; i < 4 * FRAME - 1; i++) send_bit(1'b0, 1);
    end_segment("R5");
    send_bit(1'b0, 0);
    end_segment("R5");
    check("R1", last_out, -FULL, "all-zeros output");
    check("R8", last_out, -FULL, "negative full scale");

    // R6: reset in mid-frame, then a fresh random stream
    for (int i = 0; i < 45; i++) send_bit(1'($urandom), 0);
    apply_reset();
    cur_req = "R6";
    for (int i = 0; i < 300; i++) send_bit(1'($urandom), 0);
    end_segment("R6");

    // R3: directed patterns
    apply_reset();
    cur_req = "R3";
    for (int i = 0; i < 256; i++) send_bit(1'(i % 2), 0);
    end_segment("R3");
    apply_reset();
    for (int i = 0; i < 256; i++) send_bit(1'((i / 2) % 2), 0);
    end_segment("R3");
    apply_reset();
    for (int i = 0; i < 320; i++) send_bit(i >= 150, 0);
    end_segment("R3");

    // R7: random densities with idle gaps carrying junk on bit_in
    cur_req = "R7";
    for (int p = 10; p <= 90; p += 40) begin
      apply_reset();
      for (int i = 0; i < 320; i++)
        send_bit($urandom_range(99) < p, $urandom_range(3));
      end_segment("R7");
    end

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    #400000;
    if (!finished) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: run state actual hung expected complete");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

endmodule